// File: doc/BRIEF.md
# Guest Register State Loader

This block commits a saved guest register image into the architectural control, debug and model-specific registers when a virtual machine is entered. A start pulse launches a short sequence. In one cycle every register is written from its guest field, using per-bit preservation and forcing masks and the entry-control bits. In the following cycles an ordered list of address/value pairs is read one entry per cycle and written over the field results.

The loader holds the register bank itself. Every register value is visible on a flat output, with one write-enable per register for the cycle in which it is written. The list is read through an index output and a same-cycle address/data return. A one-cycle done pulse ends each run.

Register index order (low slice of `regs_o` first): 0 CR0, 1 CR3, 2 CR4, 3 DR7, 4 debug-control, 5 sysenter CS, 6 sysenter stack pointer, 7 sysenter instruction pointer, 8 FS base, 9 GS base, 10 PAT, 11 EFER, 12 perf-global-control, 13 bound-config.

Top module: `guest_state_loader`

## Requirements
- R1: While reset is applied, CR0 reads 0x60000010, DR7 reads 0x400, every other register reads 0 and done is low.
- R2: On the field load, CR0 bits 4, 6 to 15, 17, 19 to 28, 29 and 30 keep their previous values. All other CR0 bits, including PG at bit 31, are taken from the guest CR0 field.
- R3: On every field load, CR3, CR4, the sysenter stack and instruction pointers and the FS and GS bases are taken from their fields.
- R4: DR7 and debug-control are written only when the load-debug control is 1. A written DR7 has bits 12, 14 and 15 forced to 0 and bit 10 forced to 1. DR7 always satisfies those four bit values.
- R5: Sysenter CS is loaded from its 32-bit field, with bits 63:32 cleared.
- R6: When the load-EFER control is 0, EFER bit 10 takes the long-mode-guest control. EFER bit 8 also takes that control, but only if bit 31 of the guest CR0 field is 1; otherwise bit 8 is kept. All other EFER bits are kept.
- R7: When the load-EFER control is 1, EFER is loaded whole from its field.
- R8: PAT, perf-global-control and bound-config are each written only when their own control bit is 1.
- R9: After the field load, list entries are applied in index order, one per cycle, and a later entry overrides an earlier one. The address codes are 0x40 debug-control, 0x41 sysenter CS, 0x42 stack pointer, 0x43 instruction pointer, 0x44 FS base, 0x45 GS base, 0x46 PAT, 0x47 EFER, 0x48 perf-global-control and 0x49 bound-config.
- R10: List entries addressed to FS base (0x44) or GS base (0x45) write nothing.
- R11: A list entry with any address outside 0x40 to 0x49 writes nothing.
- R12: After a start sampled in idle, the field load happens at the next edge and entry k at the edge after that plus k. Done is high for exactly one cycle, the cycle after the last write. A start seen while not idle is ignored.
- R13: A list count above MAX_LIST is treated as MAX_LIST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Entry start pulse |
| list_count_i | input | CW | Number of list entries |
| g_cr0_i | input | 64 | Guest CR0 field |
| g_cr3_i | input | 64 | Guest CR3 field |
| g_cr4_i | input | 64 | Guest CR4 field |
| g_dr7_i | input | 64 | Guest DR7 field |
| g_dbgctl_i | input | 64 | Guest debug-control field |
| g_sys_cs_i | input | 32 | Guest sysenter CS field |
| g_sys_esp_i | input | 64 | Guest sysenter stack pointer field |
| g_sys_eip_i | input | 64 | Guest sysenter instruction pointer field |
| g_fs_base_i | input | 64 | Guest FS base field |
| g_gs_base_i | input | 64 | Guest GS base field |
| g_pat_i | input | 64 | Guest PAT field |
| g_efer_i | input | 64 | Guest EFER field |
| g_perf_i | input | 64 | Guest perf-global-control field |
| g_bndcfg_i | input | 64 | Guest bound-config field |
| en_load_dbg_i | input | 1 | Load DR7 and debug-control |
| en_load_efer_i | input | 1 | Load EFER whole |
| en_long_guest_i | input | 1 | Long-mode guest control |
| en_load_pat_i | input | 1 | Load PAT |
| en_load_perf_i | input | 1 | Load perf-global-control |
| en_load_bnd_i | input | 1 | Load bound-config |
| list_idx_o | output | IW | Index of the list entry being read |
| list_addr_i | input | AW | Address of the indexed entry, same cycle |
| list_data_i | input | 64 | Value of the indexed entry, same cycle |
| reg_we_o | output | 14 | Per-register write enable for this cycle |
| regs_o | output | 896 | Register values, 64 bits each in index order |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A start driven before edge 0 makes the field results visible after edge 1. List entry k becomes visible after edge 2+k, and done is high during the cycle after edge n+1, where n is the clamped count. The bench keeps a queue-driven model that pops one action per rising edge. It compares every register slice and done on each falling edge, so each result is checked in exactly the cycle it is due. Separate end-of-run checks confirm hand-computed values and measure the done latency for normal and clamped counts.

// File: rtl/gsl_pkg.sv
// gsl_pkg: shared constants, types and reset values for the guest register
// state loader. Assumes 64-bit registers and a fixed 14-entry register bank.
package gsl_pkg;

    localparam int XLEN    = 64;
    localparam int NREG    = 14;
    localparam int IXW     = $clog2(NREG);
    localparam int NMSR    = 10;           // list-addressable registers
    localparam int FIRST_MSR = 4;          // index of the first of them

    localparam int R_CR0    = 0;
    localparam int R_CR3    = 1;
    localparam int R_CR4    = 2;
    localparam int R_DR7    = 3;
    localparam int R_DBGCTL = 4;
    localparam int R_SYSCS  = 5;
    localparam int R_SYSESP = 6;
    localparam int R_SYSEIP = 7;
    localparam int R_FSB    = 8;
    localparam int R_GSB    = 9;
    localparam int R_PAT    = 10;
    localparam int R_EFER   = 11;
    localparam int R_PERF   = 12;
    localparam int R_BND    = 13;

    localparam logic [31:0] LIST_BASE = 32'h40;

    typedef logic [XLEN-1:0] word_t;

    localparam word_t CR0_KEEP = 64'h0000_0000_7FFA_FFD0;
    localparam word_t DR7_CLR  = 64'h0000_0000_0000_D000;
    localparam word_t DR7_SET  = 64'h0000_0000_0000_0400;
    localparam word_t CR0_RST  = 64'h0000_0000_6000_0010;
    localparam int    CR0_PG   = 31;
    localparam int    EFER_LME = 8;
    localparam int    EFER_LMA = 10;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIELDS = 2'd1,
        ST_LIST   = 2'd2,
        ST_DONE   = 2'd3
    } phase_e;

    typedef struct packed {
        word_t       cr0;
        word_t       cr3;
        word_t       cr4;
        word_t       dr7;
        word_t       dbgctl;
        logic [31:0] sys_cs;
        word_t       sys_esp;
        word_t       sys_eip;
        word_t       fs_base;
        word_t       gs_base;
        word_t       pat;
        word_t       efer;
        word_t       perf;
        word_t       bndcfg;
    } guest_fields_t;

    typedef struct packed {
        logic load_dbg;
        logic load_efer;
        logic long_guest;
        logic load_pat;
        logic load_perf;
        logic load_bnd;
    } entry_ctl_t;

    // Reset value of one register of the bank.
    function automatic word_t reset_value(input int idx);
        case (idx)
            R_CR0:   return CR0_RST;
            R_DR7:   return DR7_SET;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/gsl_ctrl.sv
// gsl_ctrl: sequencing state machine of the loader. Runs idle -> field load
// (one cycle) -> list entries (one per cycle) -> done (one cycle) -> idle.
// Assumes the list count is stable on the cycle start_i is sampled.
module gsl_ctrl
    import gsl_pkg::*;
#(
    parameter int MAX_LIST = 8,
    localparam int CW = $clog2(MAX_LIST + 1),
    localparam int IW = $clog2(MAX_LIST)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [CW-1:0] count_i,
    output phase_e        phase_o,
    output logic [IW-1:0] idx_o,
    output logic          done_o
);

    phase_e        phase_q;
    logic [IW-1:0] idx_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_clamped;
    logic          last_entry;

    // Clamp the requested count to the supported depth.
    always_comb begin
        cnt_clamped = (count_i > CW'(MAX_LIST)) ? CW'(MAX_LIST) : count_i;
    end

    // Flag the entry whose write ends the list phase.
    always_comb begin
        last_entry = (CW'(idx_q) + CW'(1)) == cnt_q;
    end

    // Phase register, entry index and latched count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= ST_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                ST_IDLE: begin
                    if (start_i) begin
                        phase_q <= ST_FIELDS;
                        cnt_q   <= cnt_clamped;
                        idx_q   <= '0;
                    end
                end
                ST_FIELDS: phase_q <= (cnt_q == '0) ? ST_DONE : ST_LIST;
                ST_LIST: begin
                    idx_q <= idx_q + IW'(1);
                    if (last_entry) begin
                        phase_q <= ST_DONE;
                    end
                end
                default: phase_q <= ST_IDLE;
            endcase
        end
    end

    assign phase_o = phase_q;
    assign idx_o   = idx_q;
    assign done_o  = (phase_q == ST_DONE);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_busy_start_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != ST_IDLE) |=> (phase_q != ST_FIELDS));

    p_count_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == ST_LIST) |-> (cnt_q <= CW'(MAX_LIST)));

endmodule

// File: rtl/gsl_field_merge.sv
// gsl_field_merge: combinational next-value and write-enable computation for
// the field-load cycle. Applies the CR0 preservation mask, DR7 forcing, the
// sysenter CS width rule, EFER derivation and the per-control load gates.
module gsl_field_merge
    import gsl_pkg::*;
(
    input  word_t         cur_i [NREG],
    input  guest_fields_t fld_i,
    input  entry_ctl_t    ctl_i,
    output word_t         nxt_o [NREG],
    output logic [NREG-1:0] we_o
);

    word_t efer_derived;

    // EFER value when it is not loaded whole: mode bits follow the control.
    always_comb begin
        efer_derived           = cur_i[R_EFER];
        efer_derived[EFER_LMA] = ctl_i.long_guest;
        if (fld_i.cr0[CR0_PG]) begin
            efer_derived[EFER_LME] = ctl_i.long_guest;
        end
    end

    // Per-register field-phase value and enable.
    always_comb begin
        nxt_o = cur_i;
        we_o  = '0;

        nxt_o[R_CR0]    = (cur_i[R_CR0] & CR0_KEEP) | (fld_i.cr0 & ~CR0_KEEP);
        we_o[R_CR0]     = 1'b1;
        nxt_o[R_CR3]    = fld_i.cr3;
        we_o[R_CR3]     = 1'b1;
        nxt_o[R_CR4]    = fld_i.cr4;
        we_o[R_CR4]     = 1'b1;

        nxt_o[R_DR7]    = (fld_i.dr7 & ~DR7_CLR) | DR7_SET;
        we_o[R_DR7]     = ctl_i.load_dbg;
        nxt_o[R_DBGCTL] = fld_i.dbgctl;
        we_o[R_DBGCTL]  = ctl_i.load_dbg;

        nxt_o[R_SYSCS]  = {32'h0, fld_i.sys_cs};
        we_o[R_SYSCS]   = 1'b1;
        nxt_o[R_SYSESP] = fld_i.sys_esp;
        we_o[R_SYSESP]  = 1'b1;
        nxt_o[R_SYSEIP] = fld_i.sys_eip;
        we_o[R_SYSEIP]  = 1'b1;
        nxt_o[R_FSB]    = fld_i.fs_base;
        we_o[R_FSB]     = 1'b1;
        nxt_o[R_GSB]    = fld_i.gs_base;
        we_o[R_GSB]     = 1'b1;

        nxt_o[R_PAT]    = fld_i.pat;
        we_o[R_PAT]     = ctl_i.load_pat;
        nxt_o[R_PERF]   = fld_i.perf;
        we_o[R_PERF]    = ctl_i.load_perf;
        nxt_o[R_BND]    = fld_i.bndcfg;
        we_o[R_BND]     = ctl_i.load_bnd;

        nxt_o[R_EFER]   = ctl_i.load_efer ? fld_i.efer : efer_derived;
        we_o[R_EFER]    = 1'b1;
    end

endmodule

// File: rtl/gsl_list_decode.sv
// gsl_list_decode: maps a load-list address onto a register index. Addresses
// outside the implemented window and the two segment-base codes give no hit.
module gsl_list_decode
    import gsl_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]  addr_i,
    output logic           hit_o,
    output logic [IXW-1:0] idx_o
);

    logic [AW-1:0] offset;
    logic          in_window;

    // Offset from the window base and range test.
    always_comb begin
        offset    = addr_i - AW'(LIST_BASE);
        in_window = (addr_i >= AW'(LIST_BASE)) && (offset < AW'(NMSR));
        idx_o     = offset[IXW-1:0] + IXW'(FIRST_MSR);
    end

    // Reject out-of-window codes and the protected segment bases.
    always_comb begin
        hit_o = in_window && (idx_o != IXW'(R_FSB)) && (idx_o != IXW'(R_GSB));
    end

endmodule

// File: rtl/guest_state_loader.sv
// guest_state_loader: top of the guest register state loader. Holds the
// register bank, steers field-phase and list-phase writes into it and
// exposes every register. Assumes guest fields and controls stay stable from
// the start pulse through the field-load cycle, and that the list source
// answers the index in the same cycle.
module guest_state_loader
    import gsl_pkg::*;
#(
    parameter int MAX_LIST = 8,
    parameter int AW       = 32,
    localparam int CW = $clog2(MAX_LIST + 1),
    localparam int IW = $clog2(MAX_LIST)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [CW-1:0]        list_count_i,
    input  logic [63:0]          g_cr0_i,
    input  logic [63:0]          g_cr3_i,
    input  logic [63:0]          g_cr4_i,
    input  logic [63:0]          g_dr7_i,
    input  logic [63:0]          g_dbgctl_i,
    input  logic [31:0]          g_sys_cs_i,
    input  logic [63:0]          g_sys_esp_i,
    input  logic [63:0]          g_sys_eip_i,
    input  logic [63:0]          g_fs_base_i,
    input  logic [63:0]          g_gs_base_i,
    input  logic [63:0]          g_pat_i,
    input  logic [63:0]          g_efer_i,
    input  logic [63:0]          g_perf_i,
    input  logic [63:0]          g_bndcfg_i,
    input  logic                 en_load_dbg_i,
    input  logic                 en_load_efer_i,
    input  logic                 en_long_guest_i,
    input  logic                 en_load_pat_i,
    input  logic                 en_load_perf_i,
    input  logic                 en_load_bnd_i,
    output logic [IW-1:0]        list_idx_o,
    input  logic [AW-1:0]        list_addr_i,
    input  logic [63:0]          list_data_i,
    output logic [NREG-1:0]      reg_we_o,
    output logic [NREG*XLEN-1:0] regs_o,
    output logic                 done_o
);

    guest_fields_t   fields;
    entry_ctl_t      ctl;
    phase_e          phase;
    word_t           bank_q  [NREG];
    word_t           fm_nxt  [NREG];
    logic [NREG-1:0] fm_we;
    logic            dec_hit;
    logic [IXW-1:0]  dec_idx;
    logic [NREG-1:0] we;

    // Gather the flat ports into the shared bundle types.
    always_comb begin
        fields = '{cr0: g_cr0_i, cr3: g_cr3_i, cr4: g_cr4_i, dr7: g_dr7_i,
                   dbgctl: g_dbgctl_i, sys_cs: g_sys_cs_i,
                   sys_esp: g_sys_esp_i, sys_eip: g_sys_eip_i,
                   fs_base: g_fs_base_i, gs_base: g_gs_base_i, pat: g_pat_i,
                   efer: g_efer_i, perf: g_perf_i, bndcfg: g_bndcfg_i};
        ctl    = '{load_dbg: en_load_dbg_i, load_efer: en_load_efer_i,
                   long_guest: en_long_guest_i, load_pat: en_load_pat_i,
                   load_perf: en_load_perf_i, load_bnd: en_load_bnd_i};
    end

    gsl_ctrl #(.MAX_LIST(MAX_LIST)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .count_i (list_count_i),
        .phase_o (phase),
        .idx_o   (list_idx_o),
        .done_o  (done_o)
    );

    gsl_field_merge u_merge (
        .cur_i (bank_q),
        .fld_i (fields),
        .ctl_i (ctl),
        .nxt_o (fm_nxt),
        .we_o  (fm_we)
    );

    gsl_list_decode #(.AW(AW)) u_decode (
        .addr_i (list_addr_i),
        .hit_o  (dec_hit),
        .idx_o  (dec_idx)
    );

    for (genvar gi = 0; gi < NREG; gi++) begin : g_bank
        // Select the write source for this register by phase.
        always_comb begin
            we[gi] = ((phase == ST_FIELDS) && fm_we[gi]) ||
                     ((phase == ST_LIST) && dec_hit && (dec_idx == IXW'(gi)));
        end

        // Register storage with its architectural reset value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[gi] <= reset_value(gi);
            end else if (we[gi]) begin
                bank_q[gi] <= (phase == ST_FIELDS) ? fm_nxt[gi] : list_data_i;
            end
        end

        assign regs_o[gi*XLEN +: XLEN] = bank_q[gi];
    end

    assign reg_we_o = we;

    p_cr0_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_FIELDS) |=>
            (((bank_q[R_CR0] ^ $past(bank_q[R_CR0])) & CR0_KEEP) == '0));

    p_cr3_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_FIELDS) |=> (bank_q[R_CR3] == $past(g_cr3_i)));

    p_dr7_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q[R_DR7][10] && !bank_q[R_DR7][12] &&
        !bank_q[R_DR7][14] && !bank_q[R_DR7][15]);

    p_dbg_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == ST_FIELDS) && !en_load_dbg_i) |=>
            ($stable(bank_q[R_DR7]) && $stable(bank_q[R_DBGCTL])));

    p_syscs_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_FIELDS) |=> (bank_q[R_SYSCS][63:32] == 32'h0));

    p_efer_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == ST_FIELDS) && !en_load_efer_i) |=>
            (bank_q[R_EFER][EFER_LMA] == $past(en_long_guest_i)));

    p_efer_whole_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == ST_FIELDS) && en_load_efer_i) |=>
            (bank_q[R_EFER] == $past(g_efer_i)));

    p_pat_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == ST_FIELDS) && !en_load_pat_i) |=> $stable(bank_q[R_PAT]));

    p_seg_protect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_LIST) |-> (!we[R_FSB] && !we[R_GSB]));

    p_list_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_LIST) |-> $onehot0(we));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == ST_IDLE) || (phase == ST_DONE)) |-> (we == '0));

endmodule

// File: tb/test_guest_state_loader.sv
// Bench for guest_state_loader: queue-driven reference model updated on each
// rising edge, every register and done compared on each falling edge, plus
// hand-computed end-of-scenario checks.
module test_guest_state_loader;

    localparam int CLK_PERIOD = 10;
    localparam int MAXL = 8;
    localparam int NR = 14;
    localparam int WATCHDOG = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [3:0]  cnt = '0;
    logic [63:0] f_cr0 = '0, f_cr3 = '0, f_cr4 = '0, f_dr7 = '0, f_dbg = '0;
    logic [31:0] f_cs = '0;
    logic [63:0] f_esp = '0, f_eip = '0, f_fs = '0, f_gs = '0, f_pat = '0;
    logic [63:0] f_efer = '0, f_perf = '0, f_bnd = '0;
    logic c_dbg = 0, c_efer = 0, c_long = 0, c_pat = 0, c_perf = 0, c_bnd = 0;
    logic [2:0]  lidx;
    logic [31:0] laddr;
    logic [63:0] ldata;
    logic [NR-1:0]    we;
    logic [NR*64-1:0] regs;
    logic done;

    logic [31:0] lst_addr [16];
    logic [63:0] lst_data [16];

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    logic [63:0] m_reg [NR];
    int q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign laddr = lst_addr[lidx];
    assign ldata = lst_data[lidx];

    guest_state_loader #(.MAX_LIST(MAXL), .AW(32)) i_guest_state_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start), .list_count_i(cnt),
        .g_cr0_i(f_cr0), .g_cr3_i(f_cr3), .g_cr4_i(f_cr4), .g_dr7_i(f_dr7),
        .g_dbgctl_i(f_dbg), .g_sys_cs_i(f_cs), .g_sys_esp_i(f_esp),
        .g_sys_eip_i(f_eip), .g_fs_base_i(f_fs), .g_gs_base_i(f_gs),
        .g_pat_i(f_pat), .g_efer_i(f_efer), .g_perf_i(f_perf),
        .g_bndcfg_i(f_bnd), .en_load_dbg_i(c_dbg), .en_load_efer_i(c_efer),
        .en_long_guest_i(c_long), .en_load_pat_i(c_pat),
        .en_load_perf_i(c_perf), .en_load_bnd_i(c_bnd),
        .list_idx_o(lidx), .list_addr_i(laddr), .list_data_i(ldata),
        .reg_we_o(we), .regs_o(regs), .done_o(done)
    );

    function automatic logic [63:0] rd(input int i);
        return regs[i*64 +: 64];
    endfunction

    function automatic string req_of(input int i);
        case (i)
            0: return "R2";
            3, 4: return "R4";
            5: return "R5";
            10, 12, 13: return "R8";
            11: return "R6";
            default: return "R3";
        endcase
    endfunction

    // CR0 bits that survive an entry, listed as ranges.
    function automatic bit cr0_kept(input int b);
        return (b == 4) || (b >= 6 && b <= 15) || (b == 17) ||
               (b >= 19 && b <= 30);
    endfunction

    task automatic chk(input string tag, input logic [63:0] got,
                       input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NR; i++) m_reg[i] = 64'h0;
        m_reg[0] = 64'h6000_0010;
        m_reg[3] = 64'h400;
        q.delete();
    endtask

    task automatic model_fields();
        logic [63:0] v;
        for (int b = 0; b < 64; b++)
            if (!cr0_kept(b)) m_reg[0][b] = f_cr0[b];
        m_reg[1] = f_cr3;
        m_reg[2] = f_cr4;
        if (c_dbg) begin
            v = f_dr7;
            v[12] = 0; v[14] = 0; v[15] = 0; v[10] = 1;
            m_reg[3] = v;
            m_reg[4] = f_dbg;
        end
        m_reg[5] = {32'h0, f_cs};
        m_reg[6] = f_esp;
        m_reg[7] = f_eip;
        m_reg[8] = f_fs;
        m_reg[9] = f_gs;
        if (c_pat)  m_reg[10] = f_pat;
        if (c_perf) m_reg[12] = f_perf;
        if (c_bnd)  m_reg[13] = f_bnd;
        if (c_efer) m_reg[11] = f_efer;
        else begin
            m_reg[11][10] = c_long;
            if (f_cr0[31]) m_reg[11][8] = c_long;
        end
    endtask

    task automatic model_entry(input int k);
        int a;
        a = int'(lst_addr[k]);
        if (a >= 'h40 && a <= 'h49 && a != 'h44 && a != 'h45)
            m_reg[a - 'h3C] = lst_data[k];
    endtask

    // Reference model: one queued action per rising edge.
    always @(posedge clk) begin
        int n, a;
        if (!rst_n) model_reset();
        else if (q.size() == 0) begin
            if (start) begin
                n = (int'(cnt) > MAXL) ? MAXL : int'(cnt);
                q.push_back(-1);
                for (int k = 0; k < n; k++) q.push_back(k);
                q.push_back(-2);
            end
        end else begin
            a = q.pop_front();
            if (a == -1) model_fields();
            else if (a >= 0) model_entry(a);
        end
    end

    // Compare every register and done on each falling edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            for (int i = 0; i < NR; i++) chk(req_of(i), rd(i), m_reg[i]);
            chk("R12 done", {63'h0, done},
                {63'h0, (q.size() > 0 && q[0] == -2)});
        end
        if (cycles > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog got=%0d expected<%0d", cycles, WATCHDOG);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Pulse start and return the falling edge count at which done appeared.
    task automatic run(output int lat, input int extra_start_at);
        int t;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        t = 1;
        while (!done && t < 100) begin
            @(negedge clk);
            t++;
            if (t == extra_start_at) start = 1'b1;
            else start = 1'b0;
        end
        lat = t;
        start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int lat, dones;
        for (int k = 0; k < 16; k++) begin
            lst_addr[k] = 32'h99;
            lst_data[k] = 64'h0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state visible while reset held
        chk("R1 cr0", rd(0), 64'h6000_0010);
        chk("R1 dr7", rd(3), 64'h400);
        chk("R1 pat", rd(10), 64'h0);
        chk("R1 done", {63'h0, done}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Scenario A: all loads, derived EFER with PG set, no list
        f_cr0 = '1; f_cr3 = 64'h1000; f_cr4 = 64'h20; f_dr7 = '1; f_dbg = 64'h3;
        f_cs = 32'hDEAD_BEEF; f_esp = 64'h1111; f_eip = 64'h2222;
        f_fs = 64'hF5; f_gs = 64'h65; f_pat = 64'h0007_0406_0007_0406;
        f_efer = 64'hFFF; f_perf = 64'hF; f_bnd = 64'h3;
        c_dbg = 1; c_efer = 0; c_long = 1; c_pat = 1; c_perf = 1; c_bnd = 1;
        cnt = 0;
        run(lat, 0);
        chk("R2 cr0 merge", rd(0), 64'hFFFF_FFFF_E005_003F);
        chk("R3 cr3", rd(1), 64'h1000);
        chk("R4 dr7 forced", rd(3), 64'hFFFF_FFFF_FFFF_2FFF);
        chk("R5 syscs", rd(5), 64'h0000_0000_DEAD_BEEF);
        chk("R6 efer lma+lme", rd(11), 64'h500);
        chk("R12 latency n=0", lat, 2);

        // Scenario B: gated loads off, PG clear keeps LME
        f_cr0 = '0; f_dr7 = '0; f_pat = 64'h99;
        c_dbg = 0; c_long = 0; c_pat = 0; c_perf = 0; c_bnd = 0;
        run(lat, 0);
        chk("R2 cr0 keep", rd(0), 64'h6000_0010);
        chk("R6 efer lme kept", rd(11), 64'h100);
        chk("R4 dr7 not loaded", rd(3), 64'hFFFF_FFFF_FFFF_2FFF);
        chk("R8 pat not loaded", rd(10), 64'h0007_0406_0007_0406);

        // Scenario C: whole EFER load
        c_efer = 1; f_efer = 64'hD01;
        run(lat, 0);
        chk("R7 efer whole", rd(11), 64'hD01);

        // Scenario D: list overrides, segment and unknown drops, busy start
        c_pat = 1; f_pat = 64'h55;
        lst_addr[0] = 32'h46; lst_data[0] = 64'h11;
        lst_addr[1] = 32'h46; lst_data[1] = 64'h22;
        lst_addr[2] = 32'h44; lst_data[2] = 64'h0BAD_0BAD;
        lst_addr[3] = 32'h99; lst_data[3] = 64'h0BAD_0BAD;
        lst_addr[4] = 32'h47; lst_data[4] = 64'h1;
        cnt = 5;
        run(lat, 3);
        chk("R9 pat last wins", rd(10), 64'h22);
        chk("R9 efer override", rd(11), 64'h1);
        chk("R10 fs base kept", rd(8), 64'hF5);
        for (int i = 0; i < NR; i++)
            if (rd(i) == 64'h0BAD_0BAD) chk("R11 unknown dropped", rd(i), 64'h0);
        n_cmp++;
        chk("R12 latency n=5", lat, 7);
        dones = 0;
        repeat (10) begin
            @(negedge clk);
            if (done) dones++;
        end
        chk("R12 no restart from busy start", dones, 0);

        // Scenario E: count above the limit is clamped
        for (int k = 0; k < 16; k++) begin
            lst_addr[k] = 32'h46;
            lst_data[k] = (k < MAXL) ? 64'h70 + k : 64'hBAD;
        end
        cnt = 4'd15;
        run(lat, 0);
        chk("R13 clamp pat", rd(10), 64'h77);
        chk("R13 clamp latency", lat, MAXL + 2);

        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule